// File: doc/BRIEF.md
# Frequency-Offset Loss-of-Lock Monitor

This block watches a recovered line clock and decides whether it still runs at the same frequency as a local reference clock. Over a measurement window of a fixed number of reference cycles it counts recovered-clock edges. A window passes when the count lies within a tolerance band around the expected count; the band is the ppm limit written as a count. A recovered-domain counter crosses into the reference domain in Gray code, and the reference side takes the difference between two successive samples.

A persistence state machine turns the window results into a single loss-of-lock flag. The flag is raised only after a run of failing windows and dropped only after a longer run of passing windows. A window of the opposite kind restarts the run. The monitor works only while the clock-recovery enable is high; otherwise the flag stays low. After reset, and whenever the enable comes back, the flag starts high and the first window result is thrown away, because that window may be partial.

States: ST_OFF (disabled, flag low), ST_PRIME (flag high, waiting for the first window to discard), ST_LOST (flag high, no passing windows yet), ST_CLEARING (flag high, counting passing windows), ST_LOCKED (flag low, no failing windows), ST_DECLARING (flag low, counting failing windows). Transitions: any state goes to ST_OFF when enable is low; ST_OFF goes to ST_PRIME when enable is high; ST_PRIME goes to ST_LOST on the first result. ST_LOST goes to ST_CLEARING on a pass. ST_CLEARING goes to ST_LOCKED on the CLR_WIN-th pass in a row, or back to ST_LOST on a fail. ST_LOCKED goes to ST_DECLARING on a fail. ST_DECLARING goes to ST_LOST on the DECL_WIN-th fail in a row, or back to ST_LOCKED on a pass.

Top module: `lol_monitor`

## Requirements
- R1: Each window lasts WINDOW_CYC reference cycles. It counts recovered-clock rising edges, and it passes when the count N satisfies EXP_CNT-TOL_CNT <= N <= EXP_CNT+TOL_CNT; otherwise it fails.
- R2: Out of reset with `cdr_en` high, `lol` is 1. The first window result after reset is discarded, and `lol` stays 1 until the clear rule is met.
- R3: While `lol` is 1, CLR_WIN passing windows in a row drop `lol` to 0.
- R4: While `lol` is 0, DECL_WIN failing windows in a row raise `lol` to 1.
- R5: A single window of the opposite kind restarts the declare or clear run, so a shorter run changes nothing.
- R6: While `cdr_en` is 0, `lol` is 0 in that same cycle. When `cdr_en` returns to 1, `lol` is 1 from the next cycle, and the first window result is again discarded.
- R7: The count is correct whatever the phase between the clocks. A rate offset inside the band counts as a pass, and an offset beyond it counts as a fail, whether the recovered clock is fast or slow.
- R8: `lol` changes only in the second reference cycle after the last cycle of a window, or because of `cdr_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock; times the windows and runs the state machine |
| rec_clk | input | 1 | Recovered clock under test |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| cdr_en | input | 1 | High in serial modes that use clock recovery; low holds the monitor off |
| lol | output | 1 | Loss-of-lock flag, 1 = frequency offset beyond tolerance |

## Verification
The recovered clock is run at the nominal rate, at a small fast offset inside the band, and at slow and fast offsets well outside it. These cases tell a band check from a plain equality check, and they exercise both limits of the band. Runs of failing windows one short of the declare count, each broken by a single pass, show that persistence restarts and does not simply accumulate. A near-limit passing run cut by one fail shows the same on the clear side. A disabled stretch with a bad clock, followed by re-enable, separates the forced-low behaviour from the restart with the flag raised and the first result discarded.

// File: rtl/lol_pkg.sv
package lol_pkg;

    typedef enum logic [2:0] {
        ST_OFF       = 3'd0,
        ST_PRIME     = 3'd1,
        ST_LOST      = 3'd2,
        ST_CLEARING  = 3'd3,
        ST_LOCKED    = 3'd4,
        ST_DECLARING = 3'd5
    } lol_state_t;

endpackage

// File: rtl/lol_rec_counter.sv
// Free-running edge counter in the recovered domain, published in Gray code.
module lol_rec_counter #(
    parameter int CNT_W = 10
) (
    input  logic             rec_clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] gray_o
);

    logic [1:0]       rst_sync_q;
    logic             rec_rst_n;
    logic [CNT_W-1:0] bin_q;
    logic [CNT_W-1:0] bin_nxt;

    // local reset: asynchronous assert, release aligned to rec_clk
    always_ff @(posedge rec_clk or negedge rst_n) begin
        if (!rst_n) begin
            rst_sync_q <= 2'b00;
        end else begin
            rst_sync_q <= {rst_sync_q[0], 1'b1};
        end
    end

    assign rec_rst_n = rst_sync_q[1];
    assign bin_nxt   = bin_q + 1'b1;

    always_ff @(posedge rec_clk or negedge rec_rst_n) begin
        if (!rec_rst_n) begin
            bin_q  <= '0;
            gray_o <= '0;
        end else begin
            bin_q  <= bin_nxt;
            gray_o <= bin_nxt ^ (bin_nxt >> 1);
        end
    end

endmodule

// File: rtl/lol_gray_sync.sv
// Multi-stage synchronizer for the Gray count, decoded to binary in the reference domain.
module lol_gray_sync #(
    parameter int CNT_W       = 10,
    parameter int SYNC_STAGES = 2
) (
    input  logic             ref_clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] gray_i,
    output logic [CNT_W-1:0] bin_o
);

    logic [SYNC_STAGES-1:0][CNT_W-1:0] stg_q;
    logic [CNT_W-1:0]                  gray_s;

    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) begin
            stg_q <= '0;
        end else begin
            stg_q[0] <= gray_i;
            for (int k = 1; k < SYNC_STAGES; k++) begin
                stg_q[k] <= stg_q[k-1];
            end
        end
    end

    assign gray_s = stg_q[SYNC_STAGES-1];

    always_comb begin
        for (int i = 0; i < CNT_W; i++) begin
            bin_o[i] = ^(gray_s >> i);
        end
    end

endmodule

// File: rtl/lol_window.sv
// Window timer plus per-window edge count and tolerance-band compare.
module lol_window #(
    parameter int WINDOW_CYC = 256,
    parameter int EXP_CNT    = 256,
    parameter int TOL_CNT    = 4,
    parameter int CNT_W      = 10
) (
    input  logic             ref_clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] bin_i,
    output logic             meas_vld_o,
    output logic             meas_ok_o
);

    localparam int WIN_W = (WINDOW_CYC > 1) ? $clog2(WINDOW_CYC) : 1;
    localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(WINDOW_CYC - 1);
    localparam logic [CNT_W-1:0] BAND_LO  = CNT_W'(EXP_CNT - TOL_CNT);
    localparam logic [CNT_W-1:0] BAND_HI  = CNT_W'(EXP_CNT + TOL_CNT);

    logic [WIN_W-1:0] win_q;
    logic             win_end;
    logic [CNT_W-1:0] last_q;
    logic [CNT_W-1:0] delta;
    logic             in_band;

    assign win_end = (win_q == WIN_LAST);
    assign delta   = bin_i - last_q;
    assign in_band = (delta >= BAND_LO) && (delta <= BAND_HI);

    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) begin
            win_q <= '0;
        end else if (win_end) begin
            win_q <= '0;
        end else begin
            win_q <= win_q + 1'b1;
        end
    end

    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) begin
            last_q     <= '0;
            meas_vld_o <= 1'b0;
            meas_ok_o  <= 1'b0;
        end else begin
            meas_vld_o <= win_end;
            if (win_end) begin
                last_q    <= bin_i;
                meas_ok_o <= in_band;
            end
        end
    end

endmodule

// File: rtl/lol_fsm.sv
// Asymmetric persistence state machine producing the loss-of-lock flag.
module lol_fsm
    import lol_pkg::*;
#(
    parameter int DECL_WIN = 2,
    parameter int CLR_WIN  = 3,
    parameter int RUN_W    = 2
) (
    input  logic             ref_clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             meas_vld_i,
    input  logic             meas_ok_i,
    output logic             lol_o,
    output lol_state_t       state_o,
    output logic [RUN_W-1:0] run_o
);

    localparam logic [RUN_W-1:0] DECL_LAST = RUN_W'(DECL_WIN - 1);
    localparam logic [RUN_W-1:0] CLR_LAST  = RUN_W'(CLR_WIN - 1);

    lol_state_t       state_q, state_n;
    logic [RUN_W-1:0] run_q, run_n;

    // state register
    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_PRIME;
            run_q   <= '0;
        end else begin
            state_q <= state_n;
            run_q   <= run_n;
        end
    end

    // next state
    always_comb begin
        state_n = state_q;
        run_n   = run_q;
        if (!en_i) begin
            state_n = ST_OFF;
            run_n   = '0;
        end else begin
            unique case (state_q)
                ST_OFF: begin
                    state_n = ST_PRIME;
                    run_n   = '0;
                end
                ST_PRIME: begin
                    if (meas_vld_i) begin
                        state_n = ST_LOST;
                        run_n   = '0;
                    end
                end
                ST_LOST: begin
                    if (meas_vld_i && meas_ok_i) begin
                        if (CLR_WIN <= 1) begin
                            state_n = ST_LOCKED;
                            run_n   = '0;
                        end else begin
                            state_n = ST_CLEARING;
                            run_n   = RUN_W'(1);
                        end
                    end
                end
                ST_CLEARING: begin
                    if (meas_vld_i) begin
                        if (!meas_ok_i) begin
                            state_n = ST_LOST;
                            run_n   = '0;
                        end else if (run_q == CLR_LAST) begin
                            state_n = ST_LOCKED;
                            run_n   = '0;
                        end else begin
                            run_n = run_q + 1'b1;
                        end
                    end
                end
                ST_LOCKED: begin
                    if (meas_vld_i && !meas_ok_i) begin
                        if (DECL_WIN <= 1) begin
                            state_n = ST_LOST;
                            run_n   = '0;
                        end else begin
                            state_n = ST_DECLARING;
                            run_n   = RUN_W'(1);
                        end
                    end
                end
                ST_DECLARING: begin
                    if (meas_vld_i) begin
                        if (meas_ok_i) begin
                            state_n = ST_LOCKED;
                            run_n   = '0;
                        end else if (run_q == DECL_LAST) begin
                            state_n = ST_LOST;
                            run_n   = '0;
                        end else begin
                            run_n = run_q + 1'b1;
                        end
                    end
                end
                default: begin
                    state_n = ST_OFF;
                    run_n   = '0;
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            ST_PRIME, ST_LOST, ST_CLEARING: lol_o = en_i;
            default:                        lol_o = 1'b0;
        endcase
    end

    assign state_o = state_q;
    assign run_o   = run_q;

endmodule

// File: rtl/lol_monitor.sv
module lol_monitor
    import lol_pkg::*;
#(
    parameter int WINDOW_CYC  = 65536,
    parameter int EXP_CNT     = WINDOW_CYC,
    parameter int TOL_CNT     = 7,
    parameter int DECL_WIN    = 2,
    parameter int CLR_WIN     = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic ref_clk,
    input  logic rec_clk,
    input  logic rst_n,
    input  logic cdr_en,
    output logic lol
);

    localparam int CNT_W  = $clog2(EXP_CNT + TOL_CNT + 1) + 1;
    localparam int RUN_MX = (DECL_WIN > CLR_WIN) ? DECL_WIN : CLR_WIN;
    localparam int RUN_W  = $clog2(RUN_MX + 1);

    logic [CNT_W-1:0] rec_gray;
    logic [CNT_W-1:0] ref_bin;
    logic             meas_vld;
    logic             meas_ok;
    lol_state_t       state;
    logic [RUN_W-1:0] run;

    lol_rec_counter #(.CNT_W(CNT_W)) u_cnt (
        .rec_clk (rec_clk),
        .rst_n   (rst_n),
        .gray_o  (rec_gray)
    );

    lol_gray_sync #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_sync (
        .ref_clk (ref_clk),
        .rst_n   (rst_n),
        .gray_i  (rec_gray),
        .bin_o   (ref_bin)
    );

    lol_window #(
        .WINDOW_CYC (WINDOW_CYC),
        .EXP_CNT    (EXP_CNT),
        .TOL_CNT    (TOL_CNT),
        .CNT_W      (CNT_W)
    ) u_win (
        .ref_clk    (ref_clk),
        .rst_n      (rst_n),
        .bin_i      (ref_bin),
        .meas_vld_o (meas_vld),
        .meas_ok_o  (meas_ok)
    );

    lol_fsm #(.DECL_WIN(DECL_WIN), .CLR_WIN(CLR_WIN), .RUN_W(RUN_W)) u_fsm (
        .ref_clk    (ref_clk),
        .rst_n      (rst_n),
        .en_i       (cdr_en),
        .meas_vld_i (meas_vld),
        .meas_ok_i  (meas_ok),
        .lol_o      (lol),
        .state_o    (state),
        .run_o      (run)
    );

endmodule

// File: rtl/lol_monitor_chk.sv
module lol_monitor_chk
    import lol_pkg::*;
#(
    parameter int DECL_WIN = 2,
    parameter int CLR_WIN  = 3,
    parameter int RUN_W    = 2
) (
    input logic             ref_clk,
    input logic             rst_n,
    input logic             cdr_en,
    input logic             lol,
    input logic             meas_vld,
    input logic             meas_ok,
    input lol_state_t       state,
    input logic [RUN_W-1:0] run
);

    localparam int RUN_MX = (DECL_WIN > CLR_WIN) ? DECL_WIN : CLR_WIN;

    // R1
    meas_pulse_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
        meas_vld |=> !meas_vld);

    // R2
    prime_exit_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
        ($past(state) == ST_PRIME && state != ST_PRIME && cdr_en) |-> (state == ST_LOST && $past(meas_vld)));

    // R3
    clear_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (state == ST_LOCKED && ($past(state) == ST_LOST || $past(state) == ST_CLEARING))
            |-> $past(meas_vld && meas_ok));

    // R4
    declare_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (state == ST_LOST && ($past(state) == ST_LOCKED || $past(state) == ST_DECLARING))
            |-> $past(meas_vld && !meas_ok));

    // R5
    run_bound_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
        int'(run) < RUN_MX);

    // R6
    disable_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
        !cdr_en |=> (state == ST_OFF));

    // R8
    flag_timing_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (lol != $past(lol)) |-> ($past(meas_vld) || cdr_en != $past(cdr_en) || $past(state) == ST_OFF));

endmodule

bind lol_monitor lol_monitor_chk #(
    .DECL_WIN (DECL_WIN),
    .CLR_WIN  (CLR_WIN),
    .RUN_W    (RUN_W)
) chk_i (
    .ref_clk  (ref_clk),
    .rst_n    (rst_n),
    .cdr_en   (cdr_en),
    .lol      (lol),
    .meas_vld (meas_vld),
    .meas_ok  (meas_ok),
    .state    (state),
    .run      (run)
);

// File: tb/lol_monitor_tb.sv
`timescale 1ns/1ps
module lol_monitor_tb_top;

    localparam int W     = 256;
    localparam int TOL   = 4;
    localparam int DECL  = 3;
    localparam int CLR   = 5;
    localparam int NWIN  = 37;
    localparam real REF_HALF = 2.5;

    localparam int M_OFF = 0, M_PRIME = 1, M_LOST = 2, M_LOCKED = 3;

    logic ref_clk = 1'b0;
    logic rec_clk = 1'b0;
    logic rst_n   = 1'b0;
    logic cdr_en  = 1'b1;
    logic lol;

    realtime rec_half = 2.5;
    int      n = 0;
    int      checks = 0;
    int      failures = 0;
    bit      done = 1'b0;
    bit      win_ok [NWIN];
    string   win_tag [NWIN];
    string   cur_tag = "R2";
    int      mst = M_PRIME;
    int      mrun = 0;

    lol_monitor #(
        .WINDOW_CYC (W),
        .EXP_CNT    (W),
        .TOL_CNT    (TOL),
        .DECL_WIN   (DECL),
        .CLR_WIN    (CLR),
        .SYNC_STAGES(2)
    ) dut_i (
        .ref_clk (ref_clk),
        .rec_clk (rec_clk),
        .rst_n   (rst_n),
        .cdr_en  (cdr_en),
        .lol     (lol)
    );

    initial forever #(REF_HALF) ref_clk = ~ref_clk;

    initial begin
        #1.3;
        forever begin
            #(rec_half);
            rec_clk = ~rec_clk;
        end
    end

    // stimulus schedule: recovered half period, enable, requirement tag per window
    function automatic void spec(input int w, output realtime h, output bit e, output string t);
        e = 1'b1;
        h = 2.5;
        if (w == 0)              t = "R2";
        else if (w <= 2)         t = "R1";
        else if (w <= 5)         t = "R3";
        else if (w <= 7)  begin  h = 2.6;   t = "R5"; end
        else if (w == 8)         t = "R5";
        else if (w <= 10) begin  h = 2.4;   t = "R5"; end
        else if (w == 11) begin  h = 2.475; t = "R7"; end
        else if (w <= 14) begin  h = 2.6;   t = "R4"; end
        else if (w <= 18) begin  h = 2.475; t = "R7"; end
        else if (w == 19) begin  h = 2.4;   t = "R5"; end
        else if (w <= 25)        t = "R3";
        else if (w <= 27) begin  h = 2.6; e = 1'b0; t = "R6"; end
        else if (w == 28)        t = "R6";
        else if (w <= 33)        t = "R8";
        else              begin  h = 2.6;   t = "R4"; end
    endfunction

    // window passes when the expected edge count lies inside the band (R1)
    function automatic bit classify(input realtime h);
        real cnt;
        cnt = real'(W) * REF_HALF / h;
        return (cnt >= real'(W - TOL)) && (cnt <= real'(W + TOL));
    endfunction

    initial begin
        for (int w = 0; w < NWIN; w++) begin
            realtime h;
            bit      e;
            string   t;
            spec(w, h, e, t);
            win_ok[w]  = classify(h);
            win_tag[w] = t;
        end
    end

    // behavioural reference: advances once per reference edge
    always @(posedge ref_clk) begin
        if (rst_n) begin
            bit ev;
            bit ok;
            int j;
            n++;
            ev = (n % W == 1) && (n > 1);
            j  = n / W - 1;
            ok = (j >= 0 && j < NWIN) ? win_ok[j] : 1'b1;
            if (!cdr_en) begin
                mst = M_OFF; mrun = 0;
            end else if (mst == M_OFF) begin
                mst = M_PRIME; mrun = 0;
            end else if (ev) begin
                if (mst == M_PRIME) begin
                    mst = M_LOST; mrun = 0;
                end else if (mst == M_LOST) begin
                    mrun = ok ? mrun + 1 : 0;
                    if (mrun >= CLR) begin mst = M_LOCKED; mrun = 0; end
                end else begin
                    mrun = ok ? 0 : mrun + 1;
                    if (mrun >= DECL) begin mst = M_LOST; mrun = 0; end
                end
            end
        end
    end

    // compare on every cycle, then apply the next window's stimulus
    always @(negedge ref_clk) begin
        if (rst_n && !done) begin
            bit exp_lol;
            exp_lol = cdr_en && (mst == M_PRIME || mst == M_LOST);
            checks++;
            if (lol !== exp_lol) begin
                failures++;
                $display("FAIL %s cycle=%0d lol actual=%0b expected=%0b", cur_tag, n, lol, exp_lol);
            end
            if (n % W == 0 && n / W < NWIN) begin
                realtime h;
                bit      e;
                string   t;
                spec(n / W, h, e, t);
                rec_half = h;
                cdr_en   = e;
                cur_tag  = t;
            end
        end
    end

    initial begin
        realtime h0;
        bit      e0;
        string   t0;
        spec(0, h0, e0, t0);
        rec_half = h0;
        cdr_en   = e0;
        repeat (5) @(negedge ref_clk);
        // R2: flag raised while held in reset with enable high
        checks++;
        if (lol !== 1'b1) begin
            failures++;
            $display("FAIL R2 reset lol actual=%0b expected=1", lol);
        end
        rst_n = 1'b1;
        wait (n >= NWIN * W + 8);
        @(negedge ref_clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(200000.0 * 2.0 * REF_HALF);
        if (!done) begin
            done = 1'b1;
            failures++;
            $display("FAIL watchdog cycle=%0d actual=running expected=finished", n);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule